// File: doc/BRIEF.md
# Per-Column Clock and Reset Selector

This block produces an independent clock and an independent asynchronous reset for every column of a register array. Each column carries two 2-bit configuration fields. One picks the clock source and the other picks the reset source. The clock can come from the shared global clock pin, from the column's own express-bus line, or from the A output of the cell at the head of the column. It can also be parked at a constant high level, which stops clocking in a column that holds no registers and saves its switching power. The reset sources mirror this set. The cell used for reset is the one at the foot of the column, and the constant choice means the column is never reset.

Each column contains one test flip-flop, clocked and reset by that column's selected sources, so the effect of the selection can be seen at the ports. An active-low power-up reset clears every column, whatever its configuration. The block also routes the global clock pin to the A inputs of the two upper corner cells and the global reset pin to the A inputs of the two lower corner cells.

Top module: `col_clkrst_sel`

## Requirements
- R1: With clock select 2'b00 a column's register captures its `d` bit on each rising edge of `glb_clk`.
- R2: With clock select 2'b01 a column's register captures its `d` bit on a rising edge of that column's `xbus_clk` bit, and on no other clock.
- R3: With clock select 2'b10 a column's register captures its `d` bit on a rising edge of that column's `head_a` bit, and on no other clock.
- R4: With clock select 2'b11 a column's register holds its value while `glb_clk`, `xbus_clk` and `head_a` all toggle.
- R5: With reset select 2'b00 a high `glb_rst` clears the column's register at once, without a clock edge, and keeps it cleared across clock edges.
- R6: With reset select 2'b01 a high bit of `xbus_rst` clears that column's register asynchronously.
- R7: With reset select 2'b10 a high bit of `foot_a` clears that column's register asynchronously.
- R8: With reset select 2'b11 the column's register is never cleared by `glb_rst`, `xbus_rst` or `foot_a`.
- R9: Column i uses only bits [2i+1:2i] of `clk_sel` and `rst_sel` and bit i of `xbus_clk`, `xbus_rst`, `head_a`, `foot_a` and `d`, so activity on one column's lines leaves every other column unchanged.
- R10: While `rst_n` is low every column register reads 0, for any select setting.
- R11: Both bits of `top_corner_a` follow `glb_clk`, and both bits of `bot_corner_a` follow `glb_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glb_clk | input | 1 | Global clock pin |
| glb_rst | input | 1 | Global reset pin, active high |
| rst_n | input | 1 | Power-up reset, active low, clears all columns |
| xbus_clk | input | NCOL | Per-column express-bus clock line |
| xbus_rst | input | NCOL | Per-column express-bus reset line, active high |
| head_a | input | NCOL | A output of the cell at each column head |
| foot_a | input | NCOL | A output of the cell at each column foot, active high as reset |
| clk_sel | input | 2*NCOL | Clock select, column i in bits [2i+1:2i] |
| rst_sel | input | 2*NCOL | Reset select, column i in bits [2i+1:2i] |
| d | input | NCOL | Data into each column's test register |
| q | output | NCOL | Each column's test register |
| top_corner_a | output | 2 | A inputs of the upper-left and upper-right corner cells |
| bot_corner_a | output | 2 | A inputs of the lower-left and lower-right corner cells |

## Verification
The assertions sample on `glb_clk` and assume two things. The select fields change only while every clock and reset source they can pick is quiet. They also assume that `d` never changes at a `glb_clk` rising edge. Under these conditions a configuration change cannot produce a capture or a clear that is not tracked. The stimulus meets both. It changes selects and `d` just after a falling edge of `glb_clk`. It first loads `d` with the value each column already holds, so that the rising edge produced by entering the constant-high clock choice captures a value that does not change anything. The express-bus and head-cell clock pulses and all reset pulses are placed between global clock edges.

// File: rtl/col_clkrst_pkg.sv
// Shared encoding of the per-column source select fields.
// Assumes every select field is exactly two bits wide.
package col_clkrst_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_GLOBAL = 2'b00,
        SRC_XBUS   = 2'b01,
        SRC_CELL   = 2'b10,
        SRC_CONST  = 2'b11
    } col_src_e;

endpackage

// File: rtl/col_clk_mux.sv
// Chooses one column's clock from four sources.
// Assumes sel is static configuration that changes only while the sources
// are quiet; the mux is not glitch-free. The constant choice parks the
// column clock high so its register sees no further edges.
module col_clk_mux
    import col_clkrst_pkg::*;
(
    input  logic             glb_clk,
    input  logic             xbus_clk,
    input  logic             head_a,
    input  logic [SEL_W-1:0] sel,
    output logic             col_clk
);

    // Source selection for the column clock.
    always_comb begin
        case (col_src_e'(sel))
            SRC_GLOBAL: col_clk = glb_clk;
            SRC_XBUS:   col_clk = xbus_clk;
            SRC_CELL:   col_clk = head_a;
            SRC_CONST:  col_clk = 1'b1;
            default:    col_clk = 1'b1;
        endcase
    end

endmodule

// File: rtl/col_rst_mux.sv
// Chooses one column's asynchronous reset from four sources and merges in
// the power-up reset. All sources are active high except rst_n. The
// constant choice means "never reset": the selected term is held inactive.
// The power-up term is applied whatever sel holds.
module col_rst_mux
    import col_clkrst_pkg::*;
(
    input  logic             rst_n,
    input  logic             glb_rst,
    input  logic             xbus_rst,
    input  logic             foot_a,
    input  logic [SEL_W-1:0] sel,
    output logic             col_rst
);

    logic picked;

    // Source selection for the column reset.
    always_comb begin
        case (col_src_e'(sel))
            SRC_GLOBAL: picked = glb_rst;
            SRC_XBUS:   picked = xbus_rst;
            SRC_CELL:   picked = foot_a;
            SRC_CONST:  picked = 1'b0;
            default:    picked = 1'b0;
        endcase
    end

    // Power-up reset overrides every column configuration.
    assign col_rst = picked | ~rst_n;

endmodule

// File: rtl/col_test_reg.sv
// One flip-flop standing for the registers of a column. It is clocked by
// the column clock and cleared asynchronously by the column reset, so the
// effect of both selections can be observed at the block ports.
module col_test_reg (
    input  logic col_clk,
    input  logic col_rst,
    input  logic d,
    output logic q
);

    // Capture on the column clock; clear at once on the column reset.
    always_ff @(posedge col_clk or posedge col_rst) begin
        if (col_rst) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/col_clkrst_sel.sv
// Per-column clock and reset selector for a register array.
// Each of NCOL columns has its own 2-bit clock select and 2-bit reset
// select (column i in bits [2i+1:2i]) and one test register. The global
// pins are also routed to the corner cells of the array.
// Assumes the select fields act as static configuration.
module col_clkrst_sel
    import col_clkrst_pkg::*;
#(
    parameter int NCOL = 8
) (
    input  logic                  glb_clk,
    input  logic                  glb_rst,
    input  logic                  rst_n,
    input  logic [NCOL-1:0]       xbus_clk,
    input  logic [NCOL-1:0]       xbus_rst,
    input  logic [NCOL-1:0]       head_a,
    input  logic [NCOL-1:0]       foot_a,
    input  logic [SEL_W*NCOL-1:0] clk_sel,
    input  logic [SEL_W*NCOL-1:0] rst_sel,
    input  logic [NCOL-1:0]       d,
    output logic [NCOL-1:0]       q,
    output logic [1:0]            top_corner_a,
    output logic [1:0]            bot_corner_a
);

    localparam int NCORNER = 2;

    logic [NCOL-1:0] col_clk;
    logic [NCOL-1:0] col_rst;

    // One clock mux, reset mux and test register for each column.
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        col_clk_mux u_clk (
            .glb_clk  (glb_clk),
            .xbus_clk (xbus_clk[c]),
            .head_a   (head_a[c]),
            .sel      (clk_sel[SEL_W*c +: SEL_W]),
            .col_clk  (col_clk[c])
        );

        col_rst_mux u_rst (
            .rst_n    (rst_n),
            .glb_rst  (glb_rst),
            .xbus_rst (xbus_rst[c]),
            .foot_a   (foot_a[c]),
            .sel      (rst_sel[SEL_W*c +: SEL_W]),
            .col_rst  (col_rst[c])
        );

        col_test_reg u_reg (
            .col_clk (col_clk[c]),
            .col_rst (col_rst[c]),
            .d       (d[c]),
            .q       (q[c])
        );
    end

    // Global pins also drive the A inputs of the corner cells.
    assign top_corner_a = {NCORNER{glb_clk}};
    assign bot_corner_a = {NCORNER{glb_rst}};

endmodule

// File: rtl/col_clkrst_sel_chk.sv
// Checker for col_clkrst_sel, bound to every instance of it. Samples on
// glb_clk. Assumes selects and d change only between global clock edges.
module col_clkrst_sel_chk #(
    parameter int NCOL = 8
) (
    input logic                glb_clk,
    input logic                glb_rst,
    input logic                rst_n,
    input logic [NCOL-1:0]     xbus_rst,
    input logic [NCOL-1:0]     foot_a,
    input logic [2*NCOL-1:0]   clk_sel,
    input logic [2*NCOL-1:0]   rst_sel,
    input logic [NCOL-1:0]     d,
    input logic [NCOL-1:0]     q
);

    // Power-up reset check at each falling global edge.
    always @(negedge glb_clk) begin
        if (!rst_n) begin
            // R10
            por_clear_chk: assert (q == '0)
                else $error("power-up reset left a column set");
        end
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_chk
        // R5
        glb_rst_clear_chk: assert property (@(posedge glb_clk) disable iff (!rst_n)
            (rst_sel[2*c +: 2] == 2'b00 && glb_rst) |-> (q[c] == 1'b0));
        // R6
        xbus_rst_clear_chk: assert property (@(posedge glb_clk) disable iff (!rst_n)
            (rst_sel[2*c +: 2] == 2'b01 && xbus_rst[c]) |-> (q[c] == 1'b0));
        // R7
        foot_rst_clear_chk: assert property (@(posedge glb_clk) disable iff (!rst_n)
            (rst_sel[2*c +: 2] == 2'b10 && foot_a[c]) |-> (q[c] == 1'b0));
        // R4
        parked_hold_chk: assert property (@(posedge glb_clk) disable iff (!rst_n)
            (clk_sel[2*c +: 2] == 2'b11 && rst_sel[2*c +: 2] == 2'b11) ##1
            (clk_sel[2*c +: 2] == 2'b11 && rst_sel[2*c +: 2] == 2'b11)
            |-> $stable(q[c]));
        // R1
        glb_capture_chk: assert property (@(posedge glb_clk) disable iff (!rst_n)
            (clk_sel[2*c +: 2] == 2'b00 && rst_sel[2*c +: 2] == 2'b11) ##1
            (clk_sel[2*c +: 2] == 2'b00 && rst_sel[2*c +: 2] == 2'b11)
            |-> (q[c] == $past(d[c])));
    end

endmodule

bind col_clkrst_sel col_clkrst_sel_chk #(.NCOL(NCOL)) u_chk (
    .glb_clk  (glb_clk),
    .glb_rst  (glb_rst),
    .rst_n    (rst_n),
    .xbus_rst (xbus_rst),
    .foot_a   (foot_a),
    .clk_sel  (clk_sel),
    .rst_sel  (rst_sel),
    .d        (d),
    .q        (q)
);

// File: tb/sim_col_clkrst_sel.sv
module sim_col_clkrst_sel;

    localparam int N = 8;
    localparam int WATCHDOG_NS = 200000;

    logic           glb_clk = 1'b0;
    logic           glb_rst, rst_n;
    logic [N-1:0]   xbus_clk, xbus_rst, head_a, foot_a, d, q;
    logic [2*N-1:0] clk_sel, rst_sel;
    logic [1:0]     top_corner_a, bot_corner_a;

    logic [N-1:0]   exp_q;
    int             checks = 0;
    int             fails  = 0;
    bit             done   = 1'b0;

    always #4 glb_clk = ~glb_clk;

    col_clkrst_sel #(.NCOL(N)) u0 (
        .glb_clk(glb_clk), .glb_rst(glb_rst), .rst_n(rst_n),
        .xbus_clk(xbus_clk), .xbus_rst(xbus_rst), .head_a(head_a), .foot_a(foot_a),
        .clk_sel(clk_sel), .rst_sel(rst_sel), .d(d), .q(q),
        .top_corner_a(top_corner_a), .bot_corner_a(bot_corner_a)
    );

    // Expected register value after one pulse of every picked clock source.
    function automatic logic exp_tick(input logic [1:0] s, input logic old,
                                      input logic dn, input logic xm, input logic hm);
        case (s)
            2'b00:   return dn;
            2'b01:   return xm ? dn : old;
            2'b10:   return hm ? dn : old;
            default: return old;
        endcase
    endfunction

    // Whether the picked reset source is active.
    function automatic logic rst_hit(input logic [1:0] s, input logic g,
                                     input logic xm, input logic fm);
        case (s)
            2'b00:   return g;
            2'b01:   return xm;
            2'b10:   return fm;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string clk_tag(input logic [1:0] s);
        case (s)
            2'b00:   return "R1";
            2'b01:   return "R2 R9";
            2'b10:   return "R3 R9";
            default: return "R4";
        endcase
    endfunction

    function automatic string rst_tag(input logic [1:0] s);
        case (s)
            2'b00:   return "R5";
            2'b01:   return "R6 R9";
            2'b10:   return "R7 R9";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input int col, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s col %0d: actual %b expected %b", tag, col, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < N; i++) check(tag, i, q[i], exp_q[i]);
    endtask

    // Change configuration with d equal to the held values and sources quiet.
    task automatic set_cfg(input logic [2*N-1:0] c, input logic [2*N-1:0] r);
        @(negedge glb_clk);
        #1 d = exp_q;
        #1 clk_sel = c; rst_sel = r;
        @(negedge glb_clk);
    endtask

    // New data, then one pulse on the chosen express and head-cell lines.
    task automatic tick(input logic [N-1:0] dn, input logic [N-1:0] xm, input logic [N-1:0] hm);
        @(negedge glb_clk);
        #1 d = dn;
        @(negedge glb_clk);
        #1 xbus_clk = xm;
        #1 xbus_clk = '0; head_a = hm;
        #1 head_a = '0;
        repeat (2) @(negedge glb_clk);
        #1;
        for (int i = 0; i < N; i++) begin
            exp_q[i] = exp_tick(clk_sel[2*i +: 2], exp_q[i], dn[i], xm[i], hm[i]);
            check(clk_tag(clk_sel[2*i +: 2]), i, q[i], exp_q[i]);
        end
    endtask

    // Hold reset sources across a global edge, check, release, check again.
    task automatic rst_pulse(input logic g, input logic [N-1:0] xm, input logic [N-1:0] fm);
        @(negedge glb_clk);
        #1 glb_rst = g; xbus_rst = xm; foot_a = fm;
        @(negedge glb_clk);
        #1;
        check("R11", 0, bot_corner_a[0], g);
        check("R11", 1, bot_corner_a[1], g);
        for (int i = 0; i < N; i++) begin
            if (rst_hit(rst_sel[2*i +: 2], g, xm[i], fm[i])) exp_q[i] = 1'b0;
            check(rst_tag(rst_sel[2*i +: 2]), i, q[i], exp_q[i]);
        end
        glb_rst = 1'b0; xbus_rst = '0; foot_a = '0;
        repeat (2) @(negedge glb_clk);
        #1;
        for (int i = 0; i < N; i++) if (clk_sel[2*i +: 2] == 2'b00) exp_q[i] = d[i];
        check_all("R1 after reset release");
    endtask

    // Pulse the power-up reset under the current configuration.
    task automatic por_pulse();
        @(negedge glb_clk);
        #1 rst_n = 1'b0;
        #1 exp_q = '0;
        check_all("R10");
        @(negedge glb_clk);
        #1 check_all("R10");
        rst_n = 1'b1;
        repeat (2) @(negedge glb_clk);
        #1;
        for (int i = 0; i < N; i++) if (clk_sel[2*i +: 2] == 2'b00) exp_q[i] = d[i];
        check_all("R1 after power-up");
    endtask

    // Main stimulus: directed corners, then seeded random phases.
    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; glb_rst = 1'b0;
        xbus_clk = '0; xbus_rst = '0; head_a = '0; foot_a = '0;
        d = '1;
        clk_sel = 16'h1B_E4; rst_sel = 16'hE4_1B;
        exp_q = '0;
        repeat (3) @(negedge glb_clk);
        #1 check_all("R10 at power-up");
        d = '0;
        rst_n = 1'b1;
        repeat (2) @(negedge glb_clk);
        #1 check_all("R1 first release");

        @(posedge glb_clk);
        #1 check("R11", 0, top_corner_a[0], 1'b1);
        check("R11", 1, top_corner_a[1], 1'b1);
        @(negedge glb_clk);
        #1 check("R11", 0, top_corner_a[0], 1'b0);
        check("R11", 1, top_corner_a[1], 1'b0);

        // Every column parked and never reset: nothing may change.
        set_cfg('1, '1);
        tick('1, '1, '1);
        rst_pulse(1'b1, '1, '1);
        // Every column on global clock and global reset.
        set_cfg('0, '0);
        tick(8'hA5, '0, '0);
        rst_pulse(1'b1, '0, '0);
        tick(8'h3C, '1, '1);
        // Every column on its head cell clock, then its express line.
        set_cfg({N{2'b10}}, {N{2'b10}});
        tick(8'hFF, '1, 8'h0F);
        rst_pulse(1'b1, '1, 8'hC3);
        set_cfg({N{2'b01}}, {N{2'b01}});
        tick(8'h5A, 8'hF0, '1);
        rst_pulse(1'b1, 8'h81, '1);

        for (int k = 0; k < 40; k++) begin
            set_cfg(16'($urandom), 16'($urandom));
            tick(8'($urandom), 8'($urandom), 8'($urandom));
            rst_pulse(1'($urandom), 8'($urandom), 8'($urandom));
            tick(8'($urandom), 8'($urandom), 8'($urandom));
            if (k % 10 == 9) por_pulse();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(WATCHDOG_NS * 1ns);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule